// File: doc/BRIEF.md
# PIPE Command Sequencer

This block sits on the controller side of a PIPE-style PHY interface for PCI Express and turns single-cycle requests from link management logic into PHY commands. It can start a receiver detection, move the PHY to another power state, or change the link rate. Each command stays applied until the PHY answers with a one-cycle `pipe_status` pulse. The sequencer then reports completion and is ready for the next request. It also forwards three per-lane level controls and masks receive-valid while a rate change is in flight.

Only one command is outstanding at a time. Requests arriving while a command is pending get no response. Illegal requests are refused at once and change no output: P2, rate code 2'b11, and detect outside P1. A command whose completion never arrives is abandoned after `TIMEOUT_CYCLES` cycles, and the output it changed returns to its previous value.

Top module: `pipe_cmd_seq`

## Requirements
- R1: After reset, `pipe_pd` is P1 (2'b10), `pipe_rate` is Gen1 (2'b00), `pipe_detect` and `det_present` are low, and no event pulse is raised.
- R2: An idle power request for P0 (2'b00), P0s (2'b01) or P1 (2'b10) drives `pipe_pd` to the code in the cycle after the request, together with a one-cycle `cmd_accept`. A `pipe_status` pulse then gives a one-cycle `cmd_done` in the following cycle.
- R3: A power request for P2 (2'b11) gives a one-cycle `cmd_reject` and leaves `pipe_pd` unchanged.
- R4: A detect request is accepted only while `pipe_pd` is P1. `pipe_detect` then stays high until completion. In any other state the request is rejected and `pipe_detect` stays low.
- R5: When a detect completes, `det_present` becomes 1 if `pipe_rxstat` is 3'b001 in the `pipe_status` cycle, and 0 otherwise (3'b000 means no receiver).
- R6: Rate codes 2'b00/2'b01/2'b10 (Gen1/Gen2/Gen3) are accepted and driven on `pipe_rate`. Code 2'b11 is rejected and `pipe_rate` keeps its value.
- R7: `rx_valid_out` is held low from the accept cycle of a rate change through its completion cycle. At all other times it follows `pipe_rxvalid`.
- R8: While a command is pending, new requests get neither accept nor reject, and `pipe_pd` and `pipe_rate` keep their values.
- R9: When requests coincide, detect takes precedence over power, and power over rate. A request that loses is dropped.
- R10: If `pipe_status` does not arrive within `TIMEOUT_CYCLES` cycles after accept, a one-cycle `cmd_timeout` is raised, `pipe_detect` drops, and the changed `pipe_pd` or `pipe_rate` returns to its prior value.
- R11: `pipe_elec_idle`, `pipe_compliance` and `pipe_rx_invert` follow the per-lane inputs `lane_idle`, `lane_compl` and `lane_invert`.
- R12: At most one of `cmd_accept`, `cmd_reject`, `cmd_done`, `cmd_timeout` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_detect | input | 1 | Request receiver detection |
| req_power | input | 1 | Request power-state change |
| req_power_state | input | 2 | Target power state code |
| req_rate | input | 1 | Request rate change |
| req_rate_code | input | 2 | Target rate code |
| cmd_accept | output | 1 | Request accepted (pulse) |
| cmd_reject | output | 1 | Request refused (pulse) |
| cmd_done | output | 1 | Command completed (pulse) |
| cmd_timeout | output | 1 | Command abandoned (pulse) |
| det_present | output | 1 | Last detect result |
| lane_idle | input | LANES | Electrical-idle request per lane |
| lane_compl | input | LANES | Negative-disparity request per lane |
| lane_invert | input | LANES | Receive polarity inversion per lane |
| pipe_pd | output | 2 | Power state to PHY |
| pipe_rate | output | 2 | Rate to PHY |
| pipe_detect | output | 1 | Receiver detect command |
| pipe_elec_idle | output | LANES | Electrical idle to PHY |
| pipe_compliance | output | LANES | Force negative disparity to PHY |
| pipe_rx_invert | output | LANES | Polarity inversion to PHY |
| pipe_status | input | 1 | PHY completion pulse |
| pipe_rxstat | input | 3 | PHY receive status |
| pipe_rxvalid | input | 1 | PHY receive valid |
| rx_valid_out | output | 1 | Gated receive valid |

## Verification
The sequencer is driven with legal power, rate and detect requests, and with each illegal form: P2, rate 2'b11, and detect from P0. These show that refusals leave the outputs untouched while accepted requests move them. Detect completions carry both result codes, which shows that the result is latched from the status cycle. Coincident requests separate the priority order from a plain first-come order. Requests issued while a command is pending check that they are ignored. Commands with no completion are run for both the power and the rate kind, which shows that the restore touches only the output that was changed.

// File: rtl/pipe_cmd_seq.sv
module pipe_cmd_seq #(
  parameter int LANES          = 4,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_detect,
  input  logic             req_power,
  input  logic [1:0]       req_power_state,
  input  logic             req_rate,
  input  logic [1:0]       req_rate_code,
  output logic             cmd_accept,
  output logic             cmd_reject,
  output logic             cmd_done,
  output logic             cmd_timeout,
  output logic             det_present,
  input  logic [LANES-1:0] lane_idle,
  input  logic [LANES-1:0] lane_compl,
  input  logic [LANES-1:0] lane_invert,
  output logic [1:0]       pipe_pd,
  output logic [1:0]       pipe_rate,
  output logic             pipe_detect,
  output logic [LANES-1:0] pipe_elec_idle,
  output logic [LANES-1:0] pipe_compliance,
  output logic [LANES-1:0] pipe_rx_invert,
  input  logic             pipe_status,
  input  logic [2:0]       pipe_rxstat,
  input  logic             pipe_rxvalid,
  output logic             rx_valid_out
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [1:0] PD_P1 = 2'b10;
  localparam logic [1:0] PD_P2 = 2'b11;
  localparam logic [1:0] RATE_BAD = 2'b11;

  typedef enum logic [1:0] {K_DET, K_PWR, K_RATE} kind_t;

  logic          busy_q, det_q, pres_q;
  logic          acc_q, rej_q, done_q, tmo_q;
  kind_t         kind_q;
  logic [1:0]    pd_q, pd_prev, rate_q, rate_prev;
  logic [TW-1:0] timer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      det_q     <= 1'b0;
      pres_q    <= 1'b0;
      acc_q     <= 1'b0;
      rej_q     <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      kind_q    <= K_DET;
      pd_q      <= PD_P1;
      pd_prev   <= PD_P1;
      rate_q    <= 2'b00;
      rate_prev <= 2'b00;
      timer_q   <= '0;
    end else begin
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      if (!busy_q) begin
        timer_q <= '0;
        if (req_detect) begin
          if (pd_q == PD_P1) begin
            busy_q <= 1'b1;
            kind_q <= K_DET;
            det_q  <= 1'b1;
            acc_q  <= 1'b1;
          end else begin
            rej_q <= 1'b1;
          end
        end else if (req_power) begin
          if (req_power_state == PD_P2) begin
            rej_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            kind_q  <= K_PWR;
            pd_prev <= pd_q;
            pd_q    <= req_power_state;
            acc_q   <= 1'b1;
          end
        end else if (req_rate) begin
          if (req_rate_code == RATE_BAD) begin
            rej_q <= 1'b1;
          end else begin
            busy_q    <= 1'b1;
            kind_q    <= K_RATE;
            rate_prev <= rate_q;
            rate_q    <= req_rate_code;
            acc_q     <= 1'b1;
          end
        end
      end else if (pipe_status) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        det_q  <= 1'b0;
        if (kind_q == K_DET) pres_q <= (pipe_rxstat == 3'b001);
      end else if (timer_q == T_LAST) begin
        busy_q <= 1'b0;
        tmo_q  <= 1'b1;
        det_q  <= 1'b0;
        if (kind_q == K_PWR)  pd_q   <= pd_prev;
        if (kind_q == K_RATE) rate_q <= rate_prev;
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  assign cmd_accept      = acc_q;
  assign cmd_reject      = rej_q;
  assign cmd_done        = done_q;
  assign cmd_timeout     = tmo_q;
  assign det_present     = pres_q;
  assign pipe_pd         = pd_q;
  assign pipe_rate       = rate_q;
  assign pipe_detect     = det_q;
  assign pipe_elec_idle  = lane_idle;
  assign pipe_compliance = lane_compl;
  assign pipe_rx_invert  = lane_invert;
  assign rx_valid_out    = pipe_rxvalid & ~(busy_q & (kind_q == K_RATE));
endmodule

// File: rtl/pipe_cmd_seq_chk.sv
module pipe_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       cmd_done,
  input logic       cmd_timeout,
  input logic [1:0] pipe_pd,
  input logic [1:0] pipe_rate,
  input logic       pipe_detect,
  input logic       pipe_status,
  input logic       rx_valid_out
);
  p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_accept, cmd_reject, cmd_done, cmd_timeout}));

  p_no_p2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_pd != 2'b11);

  p_no_bad_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_rate != 2'b11);

  p_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> ($stable(pipe_pd) && $stable(pipe_rate)));

  p_detect_in_p1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_detect |-> pipe_pd == 2'b10);

  p_done_follows_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(pipe_status));

  p_rate_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && pipe_rate != $past(pipe_rate)) |-> !rx_valid_out);

  p_timeout_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_timeout |-> !pipe_detect);
endmodule

bind pipe_cmd_seq pipe_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
  .cmd_done(cmd_done), .cmd_timeout(cmd_timeout),
  .pipe_pd(pipe_pd), .pipe_rate(pipe_rate), .pipe_detect(pipe_detect),
  .pipe_status(pipe_status), .rx_valid_out(rx_valid_out)
);

// File: tb/pipe_cmd_seq_tb.sv
module pipe_cmd_seq_tb;
  localparam int LANES = 4;
  localparam int TO    = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_detect = 0, req_power = 0, req_rate = 0;
  logic [1:0] req_power_state = 0, req_rate_code = 0;
  logic cmd_accept, cmd_reject, cmd_done, cmd_timeout, det_present;
  logic [LANES-1:0] lane_idle = 0, lane_compl = 0, lane_invert = 0;
  logic [1:0] pipe_pd, pipe_rate;
  logic pipe_detect;
  logic [LANES-1:0] pipe_elec_idle, pipe_compliance, pipe_rx_invert;
  logic pipe_status = 0, pipe_rxvalid = 0;
  logic [2:0] pipe_rxstat = 0;
  logic rx_valid_out;

  always #2 clk = ~clk;

  pipe_cmd_seq #(.LANES(LANES), .TIMEOUT_CYCLES(TO)) u_dut (.*);

  typedef struct {
    logic [3:0] ev;
    logic [1:0] pd;
    logic [1:0] rate;
    logic       det;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [1:0] m_pd = 2'b10, m_rate = 2'b00;
  logic m_det = 1'b0;

  localparam logic [3:0] EV_ACC = 4'b1000, EV_REJ = 4'b0100,
                         EV_DONE = 4'b0010, EV_TMO = 4'b0001;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(logic [3:0] ev, string tag);
    exp_t e;
    e.ev = ev; e.pd = m_pd; e.rate = m_rate; e.det = m_det; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && {cmd_accept, cmd_reject, cmd_done, cmd_timeout} != 4'b0) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected event: actual %b expected none",
                 {cmd_accept, cmd_reject, cmd_done, cmd_timeout});
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " event"}, {cmd_accept, cmd_reject, cmd_done, cmd_timeout}, e.ev);
        check({e.tag, " pd"}, pipe_pd, e.pd);
        check({e.tag, " rate"}, pipe_rate, e.rate);
        check({e.tag, " det_present"}, det_present, e.det);
      end
    end
  end

  task automatic do_power(logic [1:0] st, string tag);
    @(negedge clk);
    req_power = 1; req_power_state = st;
    if (st == 2'b11) expect_ev(EV_REJ, tag);
    else begin m_pd = st; expect_ev(EV_ACC, tag); end
    @(negedge clk);
    req_power = 0;
  endtask

  task automatic do_rate(logic [1:0] code, string tag);
    @(negedge clk);
    req_rate = 1; req_rate_code = code;
    if (code == 2'b11) expect_ev(EV_REJ, tag);
    else begin m_rate = code; expect_ev(EV_ACC, tag); end
    @(negedge clk);
    req_rate = 0;
  endtask

  task automatic do_detect(string tag);
    @(negedge clk);
    req_detect = 1;
    expect_ev(m_pd == 2'b10 ? EV_ACC : EV_REJ, tag);
    @(negedge clk);
    req_detect = 0;
  endtask

  task automatic complete(logic [2:0] st, logic was_det, string tag);
    @(negedge clk);
    pipe_status = 1; pipe_rxstat = st;
    if (was_det) m_det = (st == 3'b001);
    expect_ev(EV_DONE, tag);
    @(negedge clk);
    pipe_status = 0; pipe_rxstat = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pd", pipe_pd, 2'b10);
    check("R1 rate", pipe_rate, 2'b00);
    check("R1 detect", pipe_detect, 0);
    check("R1 det_present", det_present, 0);
    check("R1 events", {cmd_accept, cmd_reject, cmd_done, cmd_timeout}, 0);

    lane_idle = 4'b1010; lane_compl = 4'b0110; lane_invert = 4'b1001;
    #1;
    check("R11 idle", pipe_elec_idle, 4'b1010);
    check("R11 compl", pipe_compliance, 4'b0110);
    check("R11 invert", pipe_rx_invert, 4'b1001);

    do_detect("R4 detect in P1");
    check("R4 detect line high", pipe_detect, 1);
    complete(3'b001, 1, "R5 present");
    check("R4 detect line low", pipe_detect, 0);
    check("R5 present", det_present, 1);
    do_detect("R4 detect again");
    complete(3'b000, 1, "R5 absent");
    check("R5 absent", det_present, 0);

    do_power(2'b00, "R2 to P0");
    check("R2 pd P0", pipe_pd, 2'b00);
    complete(3'b000, 0, "R2 done");
    do_detect("R4 detect in P0");
    check("R4 no detect in P0", pipe_detect, 0);
    do_power(2'b11, "R3 P2");
    check("R3 pd kept", pipe_pd, 2'b00);
    do_power(2'b01, "R2 to P0s");
    complete(3'b000, 0, "R2 done P0s");
    check("R2 pd P0s", pipe_pd, 2'b01);
    do_power(2'b00, "R2 back to P0");
    complete(3'b000, 0, "R2 done P0");

    pipe_rxvalid = 1;
    #1 check("R7 pass idle", rx_valid_out, 1);
    do_rate(2'b10, "R6 Gen3");
    check("R6 rate Gen3", pipe_rate, 2'b10);
    check("R7 masked", rx_valid_out, 0);
    @(negedge clk);
    req_power = 1; req_power_state = 2'b10;
    @(negedge clk);
    req_power = 0;
    check("R8 pd unchanged", pipe_pd, 2'b00);
    check("R7 still masked", rx_valid_out, 0);
    @(negedge clk);
    pipe_status = 1; m_det = m_det;
    expect_ev(EV_DONE, "R6 rate done");
    #1 check("R7 masked in status cycle", rx_valid_out, 0);
    @(negedge clk);
    pipe_status = 0;
    #1 check("R7 restored", rx_valid_out, 1);
    do_rate(2'b11, "R6 bad rate");
    check("R6 rate kept", pipe_rate, 2'b10);

    @(negedge clk);
    req_detect = 1; req_power = 1; req_power_state = 2'b10;
    expect_ev(EV_REJ, "R9 detect wins");
    @(negedge clk);
    req_detect = 0; req_power = 0;
    check("R9 power dropped", pipe_pd, 2'b00);
    @(negedge clk);
    req_power = 1; req_power_state = 2'b10; req_rate = 1; req_rate_code = 2'b00;
    m_pd = 2'b10;
    expect_ev(EV_ACC, "R9 power wins");
    @(negedge clk);
    req_power = 0; req_rate = 0;
    check("R9 rate dropped", pipe_rate, 2'b10);
    complete(3'b000, 0, "R9 done");

    begin
      int n;
      do_rate(2'b01, "R10 rate accept");
      m_rate = 2'b10;
      expect_ev(EV_TMO, "R10 rate timeout");
      n = 1;
      while (!cmd_timeout && n < 4 * TO) begin @(negedge clk); n++; end
      check("R10 rate timeout cycle", n, TO + 1);
      check("R10 rate restored", pipe_rate, 2'b10);
      do_power(2'b00, "R10 power accept");
      m_pd = 2'b10;
      expect_ev(EV_TMO, "R10 power timeout");
      n = 1;
      while (!cmd_timeout && n < 4 * TO) begin @(negedge clk); n++; end
      check("R10 power timeout cycle", n, TO + 1);
      check("R10 pd restored", pipe_pd, 2'b10);
      check("R10 rate untouched", pipe_rate, 2'b10);
    end

    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule